// File: doc/BRIEF.md
# Receive Ring Buffer Write DMA

This block drains received packets, one data word at a time, from a receive FIFO and writes them into a circular buffer in memory. The write offset runs around a ring of selectable size. Software reads packets out of the ring and then moves a read pointer forward. A packet counts as delivered only when its last word has been written: only then does the committed write offset advance and the packet-done flag rise. Memory writes are grouped into bursts, and software sets the largest burst length.

If the next word would make the write offset meet the software read pointer, the block raises a sticky overflow flag. It then throws away the rest of that packet and stops accepting data. To restart, software must first write the read pointer and then write 1 to the packet-done flag. In spill mode, a packet that reaches the end of the ring runs on past the end rather than folding back to offset zero, so its bytes stay contiguous. The memory behind the ring must then have 1536 spare bytes after its end. The interrupt line is the OR of the flags that are enabled in an interrupt mask.

Register map (2-bit address, 16-bit data by default). At 0 is the read pointer: a byte offset whose low bits below the word size read back as zero. At 1 is the status register: bit 0 is packet done and bit 1 is overflow, both cleared by writing 1, and bit 7 is ring empty, which is read-only. At 2 is the interrupt mask, with bit 0 enabling packet done and bit 1 enabling overflow. At 3 is the configuration register: bits 1:0 select the ring size (0 = 8 KB, 1 = 16 KB, 2 = 32 KB, 3 = 64 KB), bits 4:2 set the burst code, and bit 5 enables spill mode. Burst code n, for n from 0 to 6, allows at most 16 << n bytes per burst, and code 7 puts no limit on burst length. After reset the configuration register reads 0x18: an 8 KB ring, burst code 6 (1024 bytes) and spill mode off.

Top module: `rxr_ring_dma`

## Requirements
- R1: After reset the status flags and the interrupt mask are zero. The empty bit (status bit 7) reads 1, irq is low, no memory write is issued, and the configuration register reads 0x18.
- R2: The words of a packet are written in FIFO order to consecutive word addresses, starting at the committed write offset. When the last word (fifo_eop) is accepted, status bit 0 is set.
- R3: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. The overflow bit stays set after transfers resume until software clears it.
- R4: irq is high exactly when some status flag is set and its mask bit is set.
- R5: Status bit 7 reads 1 exactly when the committed write offset equals the read pointer.
- R6: mem_wr_last marks the final word of a burst. A burst ends when it reaches the length set by the burst code, when the packet ends, when the next word would cross the ring end with spill mode off, or when the next word would overflow. Burst code 7 ends bursts only for the other three reasons.
- R7: With spill mode off, write addresses are taken modulo the selected ring size.
- R8: With spill mode on, a packet keeps counting up past the ring end. The committed offset after the packet is its end address modulo the ring size.
- R9: If the offset after the current word would equal the read pointer, that word is not written. Status bit 1 is set, the rest of the packet is dropped from the FIFO, no packet-done flag is set, and the committed offset stays where it was.
- R10: After an overflow, no data moves until the read pointer has been written and then a 1 has been written to status bit 0. Writing 1 to bit 0 before the read pointer write does not restart transfers.
- R11: While mem_wr_ready is low, mem_wr_valid, mem_wr_addr and mem_wr_data hold their values, and the FIFO is not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_empty | input | 1 | Receive FIFO has no word to offer |
| fifo_data | input | DATA_W | Word at the FIFO head |
| fifo_eop | input | 1 | Head word is the last word of its packet |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |
| mem_wr_valid | output | 1 | Write request valid |
| mem_wr_ready | input | 1 | Memory accepts the write this cycle |
| mem_wr_addr | output | ADDR_W | Byte offset of the write from the ring start |
| mem_wr_data | output | DATA_W | Write data |
| mem_wr_last | output | 1 | Final word of the current burst |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | OFF_W | Register write data |
| reg_rdata | output | OFF_W | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Packets are driven with several patterns. A short packet starting at offset zero tests ordering and the commit flag. A ten-word packet under a four-word burst limit tests limit-based burst ends against packet-end ends. A packet under alternating memory backpressure tests holding during a stall. Two long fill packets bring the write offset near the ring end, and a small packet then crosses the end once with spill mode off and once with it on, which shows folding to zero against running on past the end. A sixteen-word packet aimed at a fifteen-word gap, followed by a second packet, separates the overflow point, the dropped tail and the halt. The restart is then tried in the wrong order and in the right order.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   // Register select codes
   localparam logic [1:0] RA_RDPTR = 2'd0;
   localparam logic [1:0] RA_STAT  = 2'd1;
   localparam logic [1:0] RA_MASK  = 2'd2;
   localparam logic [1:0] RA_CFG   = 2'd3;

   // Status bit positions
   localparam int SB_DONE  = 0;
   localparam int SB_OVF   = 1;
   localparam int SB_EMPTY = 7;
   localparam int NFLAG    = 2;

   // Burst code that removes the length limit
   localparam logic [2:0] BURST_UNLIM = 3'd7;

   // Configuration register layout: [5] spill, [4:2] burst code, [1:0] ring size
   typedef struct packed {
      logic       spill;
      logic [2:0] burst;
      logic [1:0] size;
   } ring_cfg_t;

   localparam ring_cfg_t CFG_RESET = '{spill: 1'b0, burst: 3'd6, size: 2'd0};

   typedef enum logic [1:0] {
      MV_IDLE = 2'd0,
      MV_COPY = 2'd1,
      MV_DROP = 2'd2
   } mover_state_e;

endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
   import rxr_pkg::*;
#(
   parameter int OFF_W    = 16,
   parameter int STEP_LOG = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [OFF_W-1:0] reg_wdata,
   output logic [OFF_W-1:0] reg_rdata,
   input  logic [OFF_W-1:0] wr_off,
   input  logic             commit,
   input  logic             ovf_evt,
   output logic [OFF_W-1:0] rdptr,
   output ring_cfg_t        cfg,
   output logic             halted,
   output logic             irq
);

   logic [NFLAG-1:0] flag_q, mask_q, flag_set, flag_clr;
   logic [OFF_W-1:0] rdptr_q;
   ring_cfg_t        cfg_q;
   logic             halt_q, ptr_seen_q;
   logic             w_ptr, w_stat, w_mask, w_cfg, resume, empty;

   assign w_ptr  = reg_wr && (reg_addr == RA_RDPTR);
   assign w_stat = reg_wr && (reg_addr == RA_STAT);
   assign w_mask = reg_wr && (reg_addr == RA_MASK);
   assign w_cfg  = reg_wr && (reg_addr == RA_CFG);

   assign flag_set = {ovf_evt, commit};
   assign flag_clr = w_stat ? reg_wdata[NFLAG-1:0] : '0;
   assign resume   = halt_q && ptr_seen_q && w_stat && reg_wdata[SB_DONE];
   assign empty    = (wr_off == rdptr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= '0;
         mask_q  <= '0;
         rdptr_q <= '0;
         cfg_q   <= CFG_RESET;
      end else begin
         flag_q <= (flag_q & ~flag_clr) | flag_set;
         if (w_mask) mask_q  <= reg_wdata[NFLAG-1:0];
         if (w_ptr)  rdptr_q <= {reg_wdata[OFF_W-1:STEP_LOG], {STEP_LOG{1'b0}}};
         if (w_cfg)  cfg_q   <= ring_cfg_t'(reg_wdata[$bits(ring_cfg_t)-1:0]);
      end
   end

   // Two-step restart: pointer write arms, done-bit write releases
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q     <= 1'b0;
         ptr_seen_q <= 1'b0;
      end else if (ovf_evt) begin
         halt_q     <= 1'b1;
         ptr_seen_q <= 1'b0;
      end else if (resume) begin
         halt_q     <= 1'b0;
         ptr_seen_q <= 1'b0;
      end else if (halt_q && w_ptr) begin
         ptr_seen_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_RDPTR: reg_rdata = rdptr_q;
         RA_STAT:  reg_rdata = OFF_W'({empty, {(SB_EMPTY-NFLAG){1'b0}}, flag_q});
         RA_MASK:  reg_rdata = OFF_W'(mask_q);
         default:  reg_rdata = OFF_W'(cfg_q);
      endcase
   end

   assign rdptr  = rdptr_q;
   assign cfg    = cfg_q;
   assign halted = halt_q;
   assign irq    = |(flag_q & mask_q);

   AST_OVF_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> flag_q[SB_OVF] && halt_q); // R9
   AST_DONE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> flag_q[SB_DONE]); // R2
   AST_RESUME_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halt_q) |-> $past(ptr_seen_q) && $past(w_stat)); // R10
   AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[SB_DONE]) |-> $past(w_stat && reg_wdata[SB_DONE])); // R3
   AST_OVF_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[SB_OVF]) |-> $past(w_stat && reg_wdata[SB_OVF])); // R3

endmodule

// File: rtl/rxr_mover.sv
module rxr_mover
   import rxr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int OFF_W    = 16,
   parameter int ADDR_W   = 17,
   parameter int SLACK    = 1536,
   parameter bit HAS_SPILL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ring_cfg_t         cfg,
   input  logic [OFF_W-1:0]  rdptr,
   input  logic              halted,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              fifo_eop,
   output logic              fifo_rd,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              mem_wr_last,
   output logic [OFF_W-1:0]  wr_off,
   output logic              commit,
   output logic              ovf_evt
);

   localparam int STEP     = DATA_W / 8;
   localparam int STEP_LOG = $clog2(STEP);
   localparam logic [OFF_W-1:0] ALL1 = '1;

   mover_state_e      state_q;
   logic [ADDR_W-1:0] cur_q, next_off, after_off, cur_adv;
   logic [OFF_W-1:0]  wr_off_q, ring_mask, next_lo, after_lo, lim_words, beat_q;
   logic [ADDR_W-1:0] ring_bytes;
   logic              spill_eff, full_now, full_after, at_end, burst_hit, last_w, accept;

   generate
      if (HAS_SPILL) begin : g_spill
         assign spill_eff = cfg.spill;
      end else begin : g_fold
         assign spill_eff = 1'b0;
      end
   endgenerate

   assign ring_mask  = ALL1 >> (2'd3 - cfg.size);
   assign ring_bytes = ADDR_W'(ring_mask) + ADDR_W'(1);

   assign next_off   = cur_q + ADDR_W'(STEP);
   assign after_off  = cur_q + ADDR_W'(2 * STEP);
   assign next_lo    = next_off[OFF_W-1:0] & ring_mask;
   assign after_lo   = after_off[OFF_W-1:0] & ring_mask;
   assign full_now   = (next_lo == rdptr);
   assign full_after = (after_lo == rdptr);
   assign at_end     = (next_lo == '0);
   assign cur_adv    = spill_eff ? next_off : ADDR_W'(next_lo);

   assign lim_words  = (OFF_W'(16) << cfg.burst) >> STEP_LOG;
   assign burst_hit  = (cfg.burst != BURST_UNLIM) && ((beat_q + OFF_W'(1)) == lim_words);
   assign last_w     = fifo_eop || burst_hit || (!spill_eff && at_end) || full_after;

   assign mem_wr_valid = (state_q == MV_COPY) && !fifo_empty && !full_now;
   assign accept       = mem_wr_valid && mem_wr_ready;
   assign fifo_rd      = accept || ((state_q == MV_DROP) && !fifo_empty);
   assign mem_wr_addr  = cur_q;
   assign mem_wr_data  = fifo_data;
   assign mem_wr_last  = mem_wr_valid && last_w;
   assign ovf_evt      = (state_q == MV_COPY) && !fifo_empty && full_now;
   assign commit       = accept && fifo_eop;
   assign wr_off       = wr_off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= MV_IDLE;
         cur_q    <= '0;
         wr_off_q <= '0;
         beat_q   <= '0;
      end else begin
         case (state_q)
            MV_IDLE: begin
               if (!halted && !fifo_empty) begin
                  state_q <= MV_COPY;
                  cur_q   <= ADDR_W'(wr_off_q);
                  beat_q  <= '0;
               end
            end
            MV_COPY: begin
               if (ovf_evt) begin
                  state_q <= MV_DROP;
               end else if (accept) begin
                  cur_q  <= cur_adv;
                  beat_q <= last_w ? '0 : beat_q + OFF_W'(1);
                  if (fifo_eop) begin
                     wr_off_q <= next_lo;
                     state_q  <= MV_IDLE;
                  end
               end
            end
            MV_DROP: begin
               if (!fifo_empty && fifo_eop) state_q <= MV_IDLE;
            end
            default: state_q <= MV_IDLE;
         endcase
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)); // R11
   AST_NO_POP_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MV_COPY) && !mem_wr_ready |-> !fifo_rd); // R11
   AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> state_q != MV_COPY); // R10
   AST_FOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid && !spill_eff |-> mem_wr_addr < ring_bytes); // R7
   AST_SPILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> mem_wr_addr < ring_bytes + ADDR_W'(SLACK)); // R8
   AST_DROP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MV_DROP) |=> $stable(wr_off_q)); // R9

endmodule

// File: rtl/rxr_ring_dma.sv
module rxr_ring_dma
   import rxr_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int OFF_W     = 16,
   parameter int SLACK     = 1536,
   parameter bit HAS_SPILL = 1'b1,
   localparam int ADDR_W   = $clog2((1 << OFF_W) + SLACK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              fifo_eop,
   output logic              fifo_rd,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              mem_wr_last,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [OFF_W-1:0]  reg_wdata,
   output logic [OFF_W-1:0]  reg_rdata,
   output logic              irq
);

   localparam int STEP     = DATA_W / 8;
   localparam int STEP_LOG = $clog2(STEP);

   generate
      if ((DATA_W % 8) != 0 || (1 << STEP_LOG) != STEP || STEP > 16) begin : g_bad_data
         $error("rxr_ring_dma: DATA_W must be 8, 16, 32, 64 or 128");
      end
      if (OFF_W < 8 || OFF_W > 24) begin : g_bad_off
         $error("rxr_ring_dma: OFF_W must lie in 8..24");
      end
      if (SLACK < 0 || SLACK >= (1 << (OFF_W - 3))) begin : g_bad_slack
         $error("rxr_ring_dma: SLACK must be below the smallest ring size");
      end
   endgenerate

   ring_cfg_t        cfg;
   logic [OFF_W-1:0] rdptr, wr_off;
   logic             halted, commit, ovf_evt;

   rxr_regs #(
      .OFF_W   (OFF_W),
      .STEP_LOG(STEP_LOG)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .wr_off   (wr_off),
      .commit   (commit),
      .ovf_evt  (ovf_evt),
      .rdptr    (rdptr),
      .cfg      (cfg),
      .halted   (halted),
      .irq      (irq)
   );

   rxr_mover #(
      .DATA_W   (DATA_W),
      .OFF_W    (OFF_W),
      .ADDR_W   (ADDR_W),
      .SLACK    (SLACK),
      .HAS_SPILL(HAS_SPILL)
   ) u_mover (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg         (cfg),
      .rdptr       (rdptr),
      .halted      (halted),
      .fifo_empty  (fifo_empty),
      .fifo_data   (fifo_data),
      .fifo_eop    (fifo_eop),
      .fifo_rd     (fifo_rd),
      .mem_wr_valid(mem_wr_valid),
      .mem_wr_ready(mem_wr_ready),
      .mem_wr_addr (mem_wr_addr),
      .mem_wr_data (mem_wr_data),
      .mem_wr_last (mem_wr_last),
      .wr_off      (wr_off),
      .commit      (commit),
      .ovf_evt     (ovf_evt)
   );

   AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_last |-> mem_wr_valid); // R6
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !(reg_addr == RA_STAT) || (reg_rdata[1:0] != 2'b00)); // R4

endmodule

// File: tb/tb_rxr_ring_dma.sv
module tb_rxr_ring_dma;
   import rxr_pkg::*;

   localparam int DW = 32;
   localparam int OW = 16;
   localparam int AW = 17;
   localparam int RING = 8192;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fifo_empty = 1'b1;
   logic [DW-1:0] fifo_data = '0;
   logic          fifo_eop = 1'b0;
   logic          fifo_rd;
   logic          mem_wr_valid;
   logic          mem_wr_ready = 1'b1;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;
   logic          mem_wr_last;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [OW-1:0] reg_wdata = '0;
   logic [OW-1:0] reg_rdata;
   logic          irq;

   always #4 clk = ~clk;

   rxr_ring_dma #(.DATA_W(DW), .OFF_W(OW)) dut (
      .clk(clk), .rst_n(rst_n),
      .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_eop(fifo_eop), .fifo_rd(fifo_rd),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_last(mem_wr_last),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq)
   );

   int checks = 0;
   int fails = 0;
   int exp_wr = 0;
   int cyc = 0;
   int ready_alt = 0;
   logic pop_pend = 1'b0;
   logic [DW:0] fq[$];
   int   wa_log[$];
   logic wl_log[$];
   logic [DW-1:0] mem_m[int];

   // Monitor and FIFO model: decisions at the falling edge, updates after the rising edge
   always @(negedge clk) begin
      pop_pend = fifo_rd;
      if (mem_wr_valid && mem_wr_ready) begin
         wa_log.push_back(int'(mem_wr_addr));
         wl_log.push_back(mem_wr_last);
         mem_m[int'(mem_wr_addr)] = mem_wr_data;
      end
   end

   always @(posedge clk) begin
      #1;
      cyc++;
      if (pop_pend && fq.size() > 0) void'(fq.pop_front());
      pop_pend = 1'b0;
      fifo_empty = (fq.size() == 0);
      if (fq.size() > 0) {fifo_eop, fifo_data} = fq[0];
      mem_wr_ready = (ready_alt != 0) ? cyc[0] : 1'b1;
   end

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic rwr(logic [1:0] a, int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = OW'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rrd(logic [1:0] a, output int v);
      @(negedge clk);
      reg_addr = a;
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic push_pkt(int n, logic [7:0] tag);
      for (int i = 0; i < n; i++) fq.push_back({(i == n - 1), tag, 24'(i)});
   endtask

   task automatic clear_logs();
      wa_log.delete();
      wl_log.delete();
   endtask

   // Verify a packet of n words starting at base; spill chooses fold or run-on addressing
   task automatic chk_pkt(string req, int n, logic [7:0] tag, int base, bit spill);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         int a = base + 4 * i;
         if (!spill) a = a % RING;
         if (i >= wa_log.size() || wa_log[i] != a) bad++;
         else if (!mem_m.exists(a) || mem_m[a] != {tag, 24'(i)}) bad++;
      end
      chk({req, " word count"}, wa_log.size(), n);
      chk({req, " addresses and data"}, bad, 0);
   endtask

   task automatic t_reset();
      int v;
      rrd(RA_STAT, v);  chk("R1 status after reset", v, 32'h80);
      rrd(RA_MASK, v);  chk("R1 mask after reset", v, 0);
      rrd(RA_CFG, v);   chk("R1 cfg after reset", v, 32'h18);
      chk("R1 irq after reset", irq, 0);
      chk("R1 no write after reset", mem_wr_valid, 0);
   endtask

   task automatic t_single();
      int v;
      clear_logs();
      push_pkt(5, 8'hA1);
      wait_cyc(12);
      chk_pkt("R2 single packet", 5, 8'hA1, 0, 1'b0);
      exp_wr = 20;
      rrd(RA_STAT, v);  chk("R2 done flag set, R5 not empty", v, 32'h01);
      rrd(RA_RDPTR, v); chk("R5 read pointer unchanged", v, 0);
   endtask

   task automatic t_irq_w1c();
      int v;
      rwr(RA_MASK, 1);
      #1 chk("R4 irq with done enabled", irq, 1);
      rwr(RA_MASK, 2);
      #1 chk("R4 irq with only overflow enabled", irq, 0);
      rwr(RA_MASK, 3);
      rwr(RA_STAT, 0);
      rrd(RA_STAT, v); chk("R3 writing zero keeps flag", v & 3, 1);
      rwr(RA_STAT, 1);
      rrd(RA_STAT, v); chk("R3 writing one clears flag", v & 3, 0);
      #1 chk("R4 irq after clear", irq, 0);
      rwr(RA_MASK, 0);
      rwr(RA_RDPTR, exp_wr);
      rrd(RA_STAT, v); chk("R5 empty after pointer catches up", v, 32'h80);
   endtask

   task automatic t_burst();
      int v;
      int lastpos = 0;
      rwr(RA_CFG, 0 << 2);
      clear_logs();
      push_pkt(10, 8'hB2);
      wait_cyc(16);
      chk_pkt("R6 burst packet", 10, 8'hB2, exp_wr, 1'b0);
      for (int i = 0; i < wl_log.size(); i++) if (wl_log[i]) lastpos |= (1 << i);
      chk("R6 ends at 4, 8 and packet end", lastpos, (1 << 3) | (1 << 7) | (1 << 9));
      exp_wr += 40;
      rwr(RA_STAT, 3);
      rwr(RA_RDPTR, exp_wr);
      rwr(RA_CFG, 32'h18);
   endtask

   task automatic t_stall();
      clear_logs();
      ready_alt = 1;
      push_pkt(6, 8'hC3);
      wait_cyc(24);
      ready_alt = 0;
      chk_pkt("R11 backpressured packet", 6, 8'hC3, exp_wr, 1'b0);
      exp_wr += 24;
      rwr(RA_STAT, 3);
      rwr(RA_RDPTR, exp_wr);
   endtask

   // Long packet that brings the write offset to 8 bytes before the ring end
   task automatic t_fill(logic [7:0] tag);
      int n = (RING - 8 - exp_wr) / 4;
      int nl = 0;
      rwr(RA_CFG, 7 << 2);
      clear_logs();
      push_pkt(n, tag);
      wait_cyc(n + 12);
      chk_pkt("R2 fill packet", n, tag, exp_wr, 1'b0);
      foreach (wl_log[i]) if (wl_log[i]) nl++;
      chk("R6 unlimited burst ends only at packet end", nl, 1);
      exp_wr = RING - 8;
      rwr(RA_STAT, 3);
      rwr(RA_RDPTR, exp_wr);
   endtask

   task automatic t_edge(bit spill);
      int v;
      int lastpos = 0;
      rwr(RA_CFG, (spill ? 32'h20 : 0) | (6 << 2));
      clear_logs();
      push_pkt(4, spill ? 8'hE5 : 8'hD4);
      wait_cyc(12);
      for (int i = 0; i < wl_log.size(); i++) if (wl_log[i]) lastpos |= (1 << i);
      if (spill) begin
         chk_pkt("R8 spill past ring end", 4, 8'hE5, exp_wr, 1'b1);
         chk("R8 single burst when spilling", lastpos, 32'h8);
      end else begin
         chk_pkt("R7 fold at ring end", 4, 8'hD4, exp_wr, 1'b0);
         chk("R6 burst ends at ring end", lastpos, 32'hA);
      end
      exp_wr = 8;
      rwr(RA_RDPTR, exp_wr);
      rrd(RA_STAT, v);
      chk(spill ? "R8 committed offset taken modulo ring" : "R7 committed offset folded", v, 32'h81);
      rwr(RA_STAT, 3);
      rwr(RA_CFG, 32'h18);
   endtask

   task automatic t_overflow();
      int v;
      int lastpos = 0;
      rwr(RA_RDPTR, exp_wr + 64);
      clear_logs();
      push_pkt(16, 8'hF6);
      push_pkt(2, 8'h17);
      wait_cyc(30);
      chk("R9 words written before overflow", wa_log.size(), 15);
      for (int i = 0; i < wl_log.size(); i++) if (wl_log[i]) lastpos |= (1 << i);
      chk("R6 burst ends before overflowing word", lastpos, 1 << 14);
      rrd(RA_STAT, v); chk("R9 overflow flag, no done flag", v, 32'h02);
      chk("R9 dropped tail drained, next packet waits", fq.size(), 2);
      rwr(RA_STAT, 1);
      wait_cyc(20);
      chk("R10 done write before pointer write keeps halt", wa_log.size(), 15);
      rwr(RA_RDPTR, exp_wr);
      wait_cyc(20);
      chk("R10 pointer write alone keeps halt", wa_log.size(), 15);
      rrd(RA_STAT, v); chk("R5 empty with committed offset unchanged", v, 32'h82);
      clear_logs();
      rwr(RA_STAT, 1);
      wait_cyc(12);
      chk_pkt("R10 resumed packet at old offset", 2, 8'h17, exp_wr, 1'b0);
      rrd(RA_STAT, v); chk("R3 overflow flag stays after resume", v & 3, 3);
      rwr(RA_STAT, 2);
      rrd(RA_STAT, v); chk("R3 overflow flag cleared", v & 3, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_cyc(2);
      t_reset();
      t_single();
      t_irq_w1c();
      t_burst();
      t_stall();
      t_fill(8'h51);
      t_edge(1'b0);
      t_fill(8'h52);
      t_edge(1'b1);
      t_overflow();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule